// File: doc/BRIEF.md
# Multi-Channel Circular Command FIFO with Debug Peek

This block keeps command words for up to eight channels in one shared store. Each channel owns a window of that store, and the window is set by a programmable base index and an inclusive limit index. Inside its window a channel runs a circular FIFO. There is one push port and one pop port, and each of them picks a channel on every cycle. The read and write pointers of every channel leave the block directly, together with an empty flag and a full flag.

A debug path lets software inspect the store without disturbing it. A control register holds an enable bit, a channel number and a store address. While peek is enabled, a data register returns the stored word at that address. A pointer register reports the selected channel's read and write pointers. Software can therefore walk the words from a channel's read pointer to its write pointer, stepping with the same wrap rule the FIFO uses.

One register write port serves both purposes. Register addresses 0 to 7 program the windows of channels 0 to 7, and address 8 programs the peek control. A per-channel status word is selected by a separate input.

Top module: `multi_ch_fifo`

## Requirements
- R1: After reset, every base, limit and pointer is 0 and every channel reports empty. A register write to address c, where c is below the channel count, sets channel c's base from data bits 8:0 and its limit from data bits 24:16. The same write moves both of that channel's pointers to the new base, so the channel is empty afterwards.
- R2: A pointer that equals its channel's limit moves to the base on its next advance. Any other pointer moves up by one. The entry at the limit index holds data.
- R3: `pop_data_o` shows the word at the read pointer of channel `pop_ch_i`. Words come out in the order they were pushed. An accepted pop advances that channel's read pointer.
- R4: A channel is empty when its read and write pointers are equal. `stat_o` reports the empty flag of channel `stat_sel_i` at bit 10 and its full flag at bit 11. All other bits of `stat_o` are 0.
- R5: A channel is full when advancing its write pointer would make it equal the read pointer. A push to a full channel is dropped: `push_rej_o` is 1 in that cycle, and no pointer or stored word changes.
- R6: A pop from an empty channel has no effect on any pointer.
- R7: The peek control register is at address 8. Its enable is bit 31, its channel is bits 18:16 and its store address is bits 8:0. `peek_data_o` updates on the second clock edge after the control write. While enable is set it shows the stored word at the peek address; while enable is clear it is 0.
- R8: `peek_ptrs_o` reports the read pointer of the peek channel in bits 8:0 and its write pointer in bits 24:16. All other bits are 0.
- R9: Writing the peek control changes no pointer, no flag and no stored word.
- R10: Pushes, pops and setup writes to one channel leave the pointers of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address: 0..7 selects a channel window, 8 selects peek control |
| reg_wdata_i | input | 32 | Register write data |
| push_i | input | 1 | Push request |
| push_ch_i | input | 3 | Channel to push into |
| push_data_i | input | DW | Word to push |
| push_rej_o | output | 1 | The push in this cycle is dropped because the channel is full |
| pop_i | input | 1 | Pop request |
| pop_ch_i | input | 3 | Channel to pop from |
| pop_data_o | output | DW | Word at the read pointer of the pop channel |
| rd_ptr_o | output | NUM_CH*AW | Read pointers; channel c occupies bits c*AW +: AW |
| wr_ptr_o | output | NUM_CH*AW | Write pointers, packed the same way |
| empty_o | output | NUM_CH | Empty flag of each channel |
| full_o | output | NUM_CH | Full flag of each channel |
| stat_sel_i | input | 3 | Channel shown on stat_o |
| stat_o | output | 32 | Status word: bit 10 is empty, bit 11 is full |
| peek_data_o | output | DW | Registered peek read data |
| peek_ptrs_o | output | 32 | Pointers of the peek channel |

## Verification
The bench uses the default parameters: eight channels, a 512-entry store and 32-bit words. It programs windows of only four entries, so the full condition, a dropped push and a wrap from the limit back to the base all occur within a handful of operations. A second channel with its own window, placed far from the first in the store, exercises channel independence. The same channel is then used for peek reads at a chosen store address, which also tests the one-cycle read latency.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
  localparam int CH_W       = 3;
  localparam int REG_AW     = 4;
  localparam logic [REG_AW-1:0] PEEK_SEL = 4'd8;
  localparam int LIMIT_LSB  = 16;
  localparam int PEEK_EN    = 31;
  localparam int PEEK_CH    = 16;
  localparam int WR_LSB     = 16;
  localparam int EMPTY_BIT  = 10;
  localparam int FULL_BIT   = 11;
endpackage

// File: rtl/mcf_chan.sv
module mcf_chan #(
  parameter int AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_base_i,
  input  logic [AW-1:0] cfg_limit_i,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [AW-1:0] rd_ptr_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [AW-1:0] base_q, limit_q, rd_q, wr_q;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == limit_q) ? base_q : p + 1'b1;
  endfunction

  assign empty_o  = (rd_q == wr_q);
  assign full_o   = (adv(wr_q) == rd_q);
  assign rd_ptr_o = rd_q;
  assign wr_ptr_o = wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      limit_q <= '0;
      rd_q    <= '0;
      wr_q    <= '0;
    end else if (cfg_we_i) begin
      base_q  <= cfg_base_i;
      limit_q <= cfg_limit_i;
      rd_q    <= cfg_base_i;
      wr_q    <= cfg_base_i;
    end else begin
      if (push_i && !full_o) wr_q <= adv(wr_q);
      if (pop_i && !empty_o) rd_q <= adv(rd_q);
    end
  end
endmodule

// File: rtl/mcf_store.sv
module mcf_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  input  logic          peek_en_i,
  input  logic [AW-1:0] peek_addr_i,
  output logic [DW-1:0] peek_data_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] peek_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];

  // registered peek port, separate from the FIFO read path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        peek_q <= '0;
    else if (peek_en_i) peek_q <= mem[peek_addr_i];
    else                peek_q <= '0;
  end

  assign peek_data_o = peek_q;
endmodule

// File: rtl/multi_ch_fifo.sv
module multi_ch_fifo
  import mcf_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DEPTH  = 512,
  parameter int DW     = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [REG_AW-1:0]    reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  input  logic                 push_i,
  input  logic [CH_W-1:0]      push_ch_i,
  input  logic [DW-1:0]        push_data_i,
  output logic                 push_rej_o,
  input  logic                 pop_i,
  input  logic [CH_W-1:0]      pop_ch_i,
  output logic [DW-1:0]        pop_data_o,
  output logic [NUM_CH*AW-1:0] rd_ptr_o,
  output logic [NUM_CH*AW-1:0] wr_ptr_o,
  output logic [NUM_CH-1:0]    empty_o,
  output logic [NUM_CH-1:0]    full_o,
  input  logic [CH_W-1:0]      stat_sel_i,
  output logic [31:0]          stat_o,
  output logic [DW-1:0]        peek_data_o,
  output logic [31:0]          peek_ptrs_o
);
  logic [AW-1:0]   rd_ptr [NUM_CH];
  logic [AW-1:0]   wr_ptr [NUM_CH];
  logic            push_ok, push_ch_ok, pop_ch_ok;
  logic            peek_en_q;
  logic [CH_W-1:0] peek_ch_q;
  logic [AW-1:0]   peek_addr_q;

  assign push_ch_ok = int'(push_ch_i) < NUM_CH;
  assign pop_ch_ok  = int'(pop_ch_i) < NUM_CH;
  assign push_rej_o = push_i && push_ch_ok && full_o[push_ch_i];
  assign push_ok    = push_i && push_ch_ok && !full_o[push_ch_i];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic cfg_we;
    assign cfg_we = reg_we_i && (reg_addr_i == REG_AW'(c));
    mcf_chan #(.AW(AW)) i_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we),
      .cfg_base_i (reg_wdata_i[AW-1:0]),
      .cfg_limit_i(reg_wdata_i[LIMIT_LSB +: AW]),
      .push_i     (push_i && push_ch_ok && (push_ch_i == CH_W'(c))),
      .pop_i      (pop_i && pop_ch_ok && (pop_ch_i == CH_W'(c))),
      .rd_ptr_o   (rd_ptr[c]),
      .wr_ptr_o   (wr_ptr[c]),
      .empty_o    (empty_o[c]),
      .full_o     (full_o[c])
    );
    assign rd_ptr_o[c*AW +: AW] = rd_ptr[c];
    assign wr_ptr_o[c*AW +: AW] = wr_ptr[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peek_en_q   <= 1'b0;
      peek_ch_q   <= '0;
      peek_addr_q <= '0;
    end else if (reg_we_i && reg_addr_i == PEEK_SEL) begin
      peek_en_q   <= reg_wdata_i[PEEK_EN];
      peek_ch_q   <= reg_wdata_i[PEEK_CH +: CH_W];
      peek_addr_q <= reg_wdata_i[AW-1:0];
    end
  end

  mcf_store #(.DW(DW), .DEPTH(DEPTH)) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (push_ok),
    .waddr_i    (wr_ptr[push_ch_i]),
    .wdata_i    (push_data_i),
    .raddr_i    (rd_ptr[pop_ch_i]),
    .rdata_o    (pop_data_o),
    .peek_en_i  (peek_en_q),
    .peek_addr_i(peek_addr_q),
    .peek_data_o(peek_data_o)
  );

  always_comb begin
    stat_o            = '0;
    stat_o[EMPTY_BIT] = empty_o[stat_sel_i];
    stat_o[FULL_BIT]  = full_o[stat_sel_i];
    peek_ptrs_o               = '0;
    peek_ptrs_o[AW-1:0]       = rd_ptr[peek_ch_q];
    peek_ptrs_o[WR_LSB +: AW] = wr_ptr[peek_ch_q];
  end
endmodule

// File: rtl/mcf_chk.sv
module mcf_chk
  import mcf_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int AW     = 9,
  parameter int DW     = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 reg_we_i,
  input logic [REG_AW-1:0]    reg_addr_i,
  input logic [31:0]          reg_wdata_i,
  input logic                 push_i,
  input logic                 pop_i,
  input logic [CH_W-1:0]      pop_ch_i,
  input logic                 push_rej_o,
  input logic [NUM_CH-1:0]    empty_o,
  input logic [NUM_CH*AW-1:0] rd_ptr_o,
  input logic [NUM_CH*AW-1:0] wr_ptr_o,
  input logic [DW-1:0]        peek_data_o
);
  // R1
  setup_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && int'(reg_addr_i) < NUM_CH) |=> empty_o[$past(reg_addr_i[CH_W-1:0])]);

  // R5
  drop_keeps_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_rej_o && !reg_we_i) |=> $stable(wr_ptr_o));

  // R6
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && int'(pop_ch_i) < NUM_CH && empty_o[pop_ch_i] && !push_i && !reg_we_i)
    |=> $stable(rd_ptr_o));

  // R7
  peek_off_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == PEEK_SEL && !reg_wdata_i[PEEK_EN]) |=> ##1 (peek_data_o == '0));

  // R9
  peek_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == PEEK_SEL && !push_i && !pop_i)
    |=> ($stable(rd_ptr_o) && $stable(wr_ptr_o) && $stable(empty_o)));
endmodule

bind multi_ch_fifo mcf_chk #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW)) i_mcf_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .push_i     (push_i),
  .pop_i      (pop_i),
  .pop_ch_i   (pop_ch_i),
  .push_rej_o (push_rej_o),
  .empty_o    (empty_o),
  .rd_ptr_o   (rd_ptr_o),
  .wr_ptr_o   (wr_ptr_o),
  .peek_data_o(peek_data_o)
);

// File: tb/test_multi_ch_fifo.sv
module test_multi_ch_fifo;
  localparam int NCH = 8;
  localparam int AW  = 9;
  localparam int DW  = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_we = 1'b0;
  logic [3:0]      reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic            push = 1'b0, pop = 1'b0;
  logic [2:0]      push_ch = '0, pop_ch = '0, stat_sel = '0;
  logic [DW-1:0]   push_data = '0;
  logic            push_rej;
  logic [DW-1:0]   pop_data, peek_data;
  logic [NCH*AW-1:0] rd_ptr, wr_ptr;
  logic [NCH-1:0]  empty, full;
  logic [31:0]     stat, peek_ptrs;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  multi_ch_fifo i_multi_ch_fifo (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .push_i(push), .push_ch_i(push_ch),
    .push_data_i(push_data), .push_rej_o(push_rej), .pop_i(pop),
    .pop_ch_i(pop_ch), .pop_data_o(pop_data), .rd_ptr_o(rd_ptr),
    .wr_ptr_o(wr_ptr), .empty_o(empty), .full_o(full),
    .stat_sel_i(stat_sel), .stat_o(stat), .peek_data_o(peek_data),
    .peek_ptrs_o(peek_ptrs)
  );

  // {op(1=pop), data, expect}: push expects push_rej, pop expects pop_data
  localparam logic [64:0] VEC [11] = '{
    {1'b0, 32'hA1, 32'd0}, {1'b0, 32'hA2, 32'd0}, {1'b0, 32'hA3, 32'd0},
    {1'b0, 32'hA4, 32'd1}, {1'b1, 32'h0,  32'hA1}, {1'b0, 32'hA5, 32'd0},
    {1'b1, 32'h0,  32'hA2}, {1'b1, 32'h0, 32'hA3}, {1'b1, 32'h0, 32'hA5},
    {1'b0, 32'hA6, 32'd0}, {1'b1, 32'h0,  32'hA6}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  function automatic logic [31:0] rp(input int c);
    return 32'(rd_ptr[c*AW +: AW]);
  endfunction
  function automatic logic [31:0] wp(input int c);
    return 32'(wr_ptr[c*AW +: AW]);
  endfunction

  initial begin : wd
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset empty", 32'(empty), 32'hFF);
    chk("R1 reset rd ptr ch2", rp(2), 0);
    chk("R7 reset peek data", peek_data, 0);

    reg_wr(4'd2, {7'd0, 9'd13, 7'd0, 9'd10});
    reg_wr(4'd5, {7'd0, 9'd103, 7'd0, 9'd100});
    @(negedge clk);
    chk("R1 setup rd ch2", rp(2), 10);
    chk("R1 setup wr ch5", wp(5), 100);
    stat_sel = 3'd2; #1;
    chk("R4 stat empty ch2", stat, 32'h400);

    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      if (VEC[i][64]) begin
        pop = 1'b1; pop_ch = 3'd2; #1;
        chk("R3 pop order", pop_data, VEC[i][31:0]);
      end else begin
        push = 1'b1; push_ch = 3'd2; push_data = VEC[i][63:32]; #1;
        chk("R5 push reject", 32'(push_rej), VEC[i][31:0]);
        if (i == 3) chk("R4 stat full ch2", stat, 32'h800);
      end
      @(posedge clk); #1;
      push = 1'b0; pop = 1'b0;
    end
    @(negedge clk);
    chk("R2 wrap rd ch2", rp(2), 11);
    chk("R2 wrap wr ch2", wp(2), 11);

    // R10: channel 5 works without touching channel 2
    @(negedge clk);
    push = 1'b1; push_ch = 3'd5; push_data = 32'h55;
    @(posedge clk); #1 push = 1'b0;
    @(negedge clk);
    chk("R10 ch2 rd kept", rp(2), 11);
    chk("R10 ch2 wr kept", wp(2), 11);
    chk("R10 ch5 wr", wp(5), 101);

    // R7 / R8 / R9 peek
    reg_wr(4'd8, 32'h8005_0064);
    chk("R8 peek ptrs", peek_ptrs, {7'd0, 9'd101, 7'd0, 9'd100});
    @(posedge clk); #1;
    chk("R7 peek data", peek_data, 32'h55);
    reg_wr(4'd8, 32'h8002_000D);
    @(posedge clk); #1;
    chk("R7 peek limit entry", peek_data, 32'hA5);
    chk("R9 ch5 rd kept", rp(5), 100);
    chk("R9 ch5 wr kept", wp(5), 101);
    reg_wr(4'd8, 32'h0005_0064);
    @(posedge clk); #1;
    chk("R7 peek disabled zero", peek_data, 0);

    // R6 pop on empty
    @(negedge clk);
    pop = 1'b1; pop_ch = 3'd5;
    @(posedge clk); #1 pop = 1'b0;
    @(negedge clk);
    pop = 1'b1; pop_ch = 3'd5;
    @(posedge clk); #1 pop = 1'b0;
    @(negedge clk);
    chk("R6 empty pop rd", rp(5), 101);
    chk("R6 empty flag", 32'(empty[5]), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule